// File: doc/BRIEF.md
# UART Image Download Engine

This block is the device side of a serial firmware download. It sits behind a byte-level UART transceiver (8 data bits, no parity, 1 stop bit, 115200 baud) and talks to it through two valid/ready byte channels: one for received bytes and one for bytes to transmit. The other side is a word-wide RAM write port. The bit-level serial logic, baud generation and the hand-over to the loaded code all live elsewhere.

A session runs in this order:

1. The engine announces itself with 0x02.
2. It collects a three-byte header: a start code followed by a 16-bit image length, low byte first.
3. It answers the header with 0x06 (accept) or 0x15 (reject).
4. It streams the image into RAM as little-endian words, starting at a fixed word address.
5. It returns a one-byte XOR checksum and waits for the host's closing 0x06.

A rejected header, a wrong closing byte, or a host that stops sending sends the engine back to its announcement. On completion the engine pulses `done` and then sits idle until the next reset.

The states and their transitions are:

- `ST_START` is the reset state and moves to `ST_ANNOUNCE` after one cycle.
- `ST_ANNOUNCE` sends 0x02 and then moves to `ST_HDR_SOH`.
- `ST_HDR_SOH`, `ST_HDR_LO` and `ST_HDR_HI` each take one header byte and advance in that order.
- `ST_HDR_REPLY` sends the accept or reject code. After a reject it goes to `ST_ANNOUNCE`. After an accept it goes to `ST_SEND_SUM` when the length is zero, and to `ST_IMAGE` otherwise.
- `ST_IMAGE` takes image bytes and moves to `ST_SEND_SUM` after the last one.
- `ST_SEND_SUM` sends the checksum and moves to `ST_WAIT_ACK`.
- `ST_WAIT_ACK` moves to `ST_DONE` on 0x06 and to `ST_ANNOUNCE` on any other byte.
- `ST_DONE` lasts one cycle and moves to `ST_HALT`, which holds until reset.
- From any receiving state, an expired gap timer moves the engine to `ST_ANNOUNCE`.

Top module: `uart_image_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tx_valid`, `rx_ready`, `mem_we`, `busy` and `done` are all low. In the next cycle `tx_valid` rises with `tx_data` = 0x02, and `busy` rises with it.
- R2: After 0x02 the engine accepts exactly three header bytes: a start code, then length bits [7:0], then length bits [15:8]. The length is the number of image bytes it then accepts before offering the checksum.
- R3: The header reply is 0x06 when the start code was 0x01, and 0x15 otherwise. After 0x15 the engine sends 0x02 again and waits for a fresh header.
- R4: Image byte i is written to word address BASE_WORD + i/4, at bits [8*(i%4)+7 : 8*(i%4)]. The write is issued (`mem_we` high for one cycle) in the cycle after the byte that fills lane 3, or after the last image byte, is accepted.
- R5: When the length is not a multiple of four, the lanes above the last image byte in the final word are written as zero.
- R6: After the last image byte the engine sends one byte equal to 0xFF XOR all image bytes. With a length of zero it sends 0xFF right after 0x06 and performs no RAM write.
- R7: If the byte after the checksum is 0x06, `done` is high for exactly one cycle (the cycle after that byte is accepted). After that, `busy`, `tx_valid` and `rx_ready` stay low until reset. Any other byte makes the engine send 0x02 again.
- R8: In any state that waits for a received byte, GAP_LIMIT consecutive cycles without an accepted byte make the engine abandon the session. `tx_valid` with 0x02 then appears in the (GAP_LIMIT+1)-th cycle after the last accepted byte. The next session writes from BASE_WORD again.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. `tx_valid` and `rx_ready` are never high together, and `busy` is high whenever either of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte available from the transceiver |
| rx_ready | output | 1 | Engine is waiting for a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered for transmission |
| tx_ready | input | 1 | Transceiver takes the offered byte |
| tx_data | output | 8 | Byte to transmit |
| mem_we | output | 1 | RAM word write strobe |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data, little-endian lanes |
| busy | output | 1 | Session in progress, from the first 0x02 until completion |
| done | output | 1 | One-cycle pulse when the session completes |

## Verification
A wrong state shows up at the ports within one byte exchange. The engine either transmits an unexpected code (for example 0x15 in place of 0x06, or a checksum one byte early or late) or it raises `rx_ready` when a transmission is due, and the bench's per-cycle comparison catches the next handshake. A corrupted lane index or word pointer shows up on the very next `mem_we` as a wrong address or data value. A timer that fires too early or too late moves the reappearance of 0x02 away from its exact expected cycle. A missing or extra `done` is caught in the cycle it occurs.

// File: rtl/uil_pkg.sv
package uil_pkg;

    // Header carries a two-byte length
    localparam int LEN_W = 16;

    localparam logic [7:0] BYTE_STX  = 8'h02;
    localparam logic [7:0] BYTE_SOH  = 8'h01;
    localparam logic [7:0] BYTE_ACK  = 8'h06;
    localparam logic [7:0] BYTE_NACK = 8'h15;

    // Initial value of the running XOR checksum
    localparam logic [7:0] SUM_SEED  = 8'hFF;

    typedef enum logic [3:0] {
        ST_START,
        ST_ANNOUNCE,
        ST_HDR_SOH,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_HDR_REPLY,
        ST_IMAGE,
        ST_SEND_SUM,
        ST_WAIT_ACK,
        ST_DONE,
        ST_HALT
    } ldr_state_t;

endpackage

// File: rtl/uil_gap_timer.sv
module uil_gap_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expired
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Fires on the LIMIT-th consecutive idle cycle of a waiting state
    assign expired = run && !kick && (cnt_q == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || kick || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/uil_xor_sum.sv
module uil_xor_sum
    import uil_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic [7:0] sum
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= SUM_SEED;
        end else if (clear) begin
            sum <= SUM_SEED;
        end else if (en) begin
            sum <= sum ^ data;
        end
    end

endmodule

// File: rtl/uil_word_pack.sv
module uil_word_pack #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              byte_en,
    input  logic              byte_last,
    input  logic [7:0]        byte_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = (LANES > 2) ? $clog2(LANES) : 1;

    logic [LANE_W-1:0] lane_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_merged;
    logic [ADDR_W-1:0] ptr_q;
    logic              word_full;

    // Drop the incoming byte into the current lane; other lanes keep their contents
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign acc_merged[g*8 +: 8] = (lane_q == LANE_W'(g)) ? byte_in : acc_q[g*8 +: 8];
    end

    assign word_full = (lane_q == LANE_W'(LANES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q    <= '0;
            acc_q     <= '0;
            ptr_q     <= BASE_WORD;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (restart) begin
                lane_q <= '0;
                acc_q  <= '0;
                ptr_q  <= BASE_WORD;
            end else if (byte_en) begin
                if (word_full || byte_last) begin
                    // Accumulator is cleared after every flush, so a partial word's upper lanes are zero
                    mem_we    <= 1'b1;
                    mem_addr  <= ptr_q;
                    mem_wdata <= acc_merged;
                    ptr_q     <= ptr_q + ADDR_W'(1);
                    lane_q    <= '0;
                    acc_q     <= '0;
                end else begin
                    acc_q  <= acc_merged;
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/uart_image_loader.sv
module uart_image_loader
    import uil_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_WORD = '0,
    parameter int                GAP_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done
);

    ldr_state_t       state_q, state_d;
    logic             rx_fire, tx_fire;
    logic             gap_expired;
    logic             hdr_ok_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left_q;
    logic [7:0]       sum;
    logic             img_byte, img_last, session_start;

    assign rx_fire       = rx_valid && rx_ready;
    assign tx_fire       = tx_valid && tx_ready;
    assign img_byte      = (state_q == ST_IMAGE) && rx_fire;
    assign img_last      = (left_q == LEN_W'(1));
    assign session_start = (state_q == ST_HDR_REPLY) && tx_fire && hdr_ok_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_START:     state_d = ST_ANNOUNCE;
            ST_ANNOUNCE:  if (tx_ready) state_d = ST_HDR_SOH;
            ST_HDR_SOH: begin
                if (rx_valid)         state_d = ST_HDR_LO;
                else if (gap_expired) state_d = ST_ANNOUNCE;
            end
            ST_HDR_LO: begin
                if (rx_valid)         state_d = ST_HDR_HI;
                else if (gap_expired) state_d = ST_ANNOUNCE;
            end
            ST_HDR_HI: begin
                if (rx_valid)         state_d = ST_HDR_REPLY;
                else if (gap_expired) state_d = ST_ANNOUNCE;
            end
            ST_HDR_REPLY: begin
                if (tx_ready) begin
                    if (!hdr_ok_q)            state_d = ST_ANNOUNCE;
                    else if (len_q == '0)     state_d = ST_SEND_SUM;
                    else                      state_d = ST_IMAGE;
                end
            end
            ST_IMAGE: begin
                if (rx_valid) begin
                    if (img_last) state_d = ST_SEND_SUM;
                end else if (gap_expired) begin
                    state_d = ST_ANNOUNCE;
                end
            end
            ST_SEND_SUM:  if (tx_ready) state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (rx_valid)         state_d = (rx_data == BYTE_ACK) ? ST_DONE : ST_ANNOUNCE;
                else if (gap_expired) state_d = ST_ANNOUNCE;
            end
            ST_DONE:      state_d = ST_HALT;
            ST_HALT:      state_d = ST_HALT;
            default:      state_d = ST_START;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        rx_ready = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_START:     busy = 1'b0;
            ST_ANNOUNCE: begin
                tx_valid = 1'b1;
                tx_data  = BYTE_STX;
            end
            ST_HDR_SOH,
            ST_HDR_LO,
            ST_HDR_HI,
            ST_IMAGE,
            ST_WAIT_ACK:  rx_ready = 1'b1;
            ST_HDR_REPLY: begin
                tx_valid = 1'b1;
                tx_data  = hdr_ok_q ? BYTE_ACK : BYTE_NACK;
            end
            ST_SEND_SUM: begin
                tx_valid = 1'b1;
                tx_data  = sum;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_HALT:      busy = 1'b0;
            default:      busy = 1'b0;
        endcase
    end

    // Header fields and remaining-byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_ok_q <= 1'b0;
            len_q    <= '0;
            left_q   <= '0;
        end else begin
            if (state_q == ST_HDR_SOH && rx_fire) hdr_ok_q   <= (rx_data == BYTE_SOH);
            if (state_q == ST_HDR_LO  && rx_fire) len_q[7:0] <= rx_data;
            if (state_q == ST_HDR_HI  && rx_fire) len_q[15:8] <= rx_data;
            if (state_q == ST_HDR_REPLY && tx_fire) begin
                left_q <= len_q;
            end else if (img_byte) begin
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    uil_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rx_ready),
        .kick    (rx_fire),
        .expired (gap_expired)
    );

    uil_xor_sum u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (session_start),
        .en    (img_byte),
        .data  (rx_data),
        .sum   (sum)
    );

    uil_word_pack #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_WORD (BASE_WORD)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (session_start),
        .byte_en   (img_byte),
        .byte_last (img_last),
        .byte_in   (rx_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/uil_checker.sv
module uil_checker #(
    parameter int GAP_LIMIT = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       mem_we,
    input logic       busy,
    input logic       done
);

    logic [31:0] idle_q;

    // Consecutive cycles spent waiting for a byte that has not come
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (rx_ready && !rx_valid) begin
            idle_q <= idle_q + 32'd1;
        end else begin
            idle_q <= '0;
        end
    end

    assert_stx_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx_valid && tx_data == 8'h02));

    assert_write_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_valid && rx_ready));

    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid && rx_ready && rx_data == 8'h06));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !rx_ready && !mem_we));

    assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (idle_q < 32'(GAP_LIMIT)));

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_one_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

endmodule

bind uart_image_loader uil_checker #(
    .GAP_LIMIT (GAP_LIMIT)
) u_uil_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .mem_we   (mem_we),
    .busy     (busy),
    .done     (done)
);

// File: tb/uart_image_loader_test.sv
`timescale 1ns/1ps
module uart_image_loader_test;

    localparam int          LIM  = 40;
    localparam logic [15:0] BASE = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        busy;
    logic        done;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    logic stall_mode = 1'b0;
    logic exp_done   = 1'b0;

    logic [7:0]  exp_tx[$];
    string       exp_tx_tag[$];
    logic [47:0] exp_wr[$];
    string       exp_wr_tag[$];

    always #5 clk = ~clk;

    uart_image_loader #(
        .ADDR_W    (16),
        .DATA_W    (32),
        .BASE_WORD (BASE),
        .GAP_LIMIT (LIM)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Transmit-side backpressure pattern
    always @(negedge clk) begin
        if (stall_mode) tx_ready = ~tx_ready;
        else            tx_ready = 1'b1;
    end

    // Per-cycle comparison against the expected event streams
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    check("R9 unexpected tx", {56'd0, tx_data}, 64'hDEAD);
                end else begin
                    check(exp_tx_tag[0], {56'd0, tx_data}, {56'd0, exp_tx[0]});
                    void'(exp_tx.pop_front());
                    void'(exp_tx_tag.pop_front());
                end
            end
            if (mem_we) begin
                if (exp_wr.size() == 0) begin
                    check("R4 unexpected write", {16'd0, mem_addr, mem_wdata}, 64'hDEAD);
                end else begin
                    check(exp_wr_tag[0], {16'd0, mem_addr, mem_wdata}, {16'd0, exp_wr[0]});
                    void'(exp_wr.pop_front());
                    void'(exp_wr_tag.pop_front());
                end
            end
            if (done || exp_done) check("R7 done pulse", {63'd0, done}, {63'd0, exp_done});
            if (tx_valid || rx_ready) check("R9 busy with traffic", {63'd0, busy}, 64'd1);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 3) ^ (i >> 2));
    endfunction

    task automatic push_tx(input logic [7:0] b, input string tag);
        exp_tx.push_back(b);
        exp_tx_tag.push_back(tag);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_reset(input logic check_r1);
        @(negedge clk);
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        exp_tx.delete();
        exp_tx_tag.delete();
        exp_wr.delete();
        exp_wr_tag.delete();
        repeat (2) @(negedge clk);
        #1;
        if (check_r1) begin
            check("R1 reset tx_valid", {63'd0, tx_valid}, 64'd0);
            check("R1 reset rx_ready", {63'd0, rx_ready}, 64'd0);
            check("R1 reset busy", {63'd0, busy}, 64'd0);
            check("R1 reset mem_we", {63'd0, mem_we}, 64'd0);
        end
        @(negedge clk);
        push_tx(8'h02, "R1 announce");
        rst_n = 1'b1;
        #1;
        if (check_r1) begin
            check("R1 first cycle tx_valid", {63'd0, tx_valid}, 64'd0);
            check("R1 first cycle busy", {63'd0, busy}, 64'd0);
            check("R1 first cycle done", {63'd0, done}, 64'd0);
        end
        @(negedge clk);
        #1;
        if (check_r1) begin
            check("R1 announce valid", {63'd0, tx_valid}, 64'd1);
            check("R1 announce byte", {56'd0, tx_data}, 64'h02);
            check("R1 busy rises", {63'd0, busy}, 64'd1);
        end
    endtask

    task automatic session(input logic [7:0] first, input int len, input int seed,
                           input logic [7:0] final_b);
        logic [7:0] sum;
        sum = 8'hFF;
        if (first != 8'h01) begin
            push_tx(8'h15, "R3 reject code");
            push_tx(8'h02, "R3 announce after reject");
        end else begin
            push_tx(8'h06, "R3 accept code");
            for (int w = 0; w < (len + 3) / 4; w++) begin
                logic [31:0] d;
                d = '0;
                for (int l = 0; l < 4; l++) begin
                    if (w * 4 + l < len) d[l*8 +: 8] = pat(seed, w * 4 + l);
                end
                exp_wr.push_back({BASE + 16'(w), d});
                exp_wr_tag.push_back((w * 4 + 4 > len) ? "R5 partial word" : "R4 full word");
            end
            for (int i = 0; i < len; i++) sum = sum ^ pat(seed, i);
            push_tx(sum, (len == 0) ? "R6 empty checksum" : "R6 checksum");
            if (final_b != 8'h06) push_tx(8'h02, "R7 announce after bad reply");
        end
        send_byte(first);
        send_byte(8'(len));
        send_byte(8'(len >> 8));
        if (first != 8'h01) return;
        for (int i = 0; i < len; i++) begin
            send_byte(pat(seed, i));
            if (i == len - 1) begin
                #1;
                check("R2 length ends image", {62'd0, tx_valid, rx_ready}, 64'b10);
            end
        end
        send_byte(final_b);
        if (final_b == 8'h06) begin
            exp_done = 1'b1;
            @(negedge clk);
            exp_done = 1'b0;
        end
    endtask

    task automatic drain_check(input string tag);
        repeat (6) @(negedge clk);
        #1;
        check({tag, " tx stream drained"}, 64'(exp_tx.size()), 64'd0);
        check({tag, " writes drained"}, 64'(exp_wr.size()), 64'd0);
    endtask

    initial begin
        // Plain aligned download
        do_reset(1'b1);
        session(8'h01, 8, 1, 8'h06);
        repeat (10) begin
            @(negedge clk);
            #1;
            check("R7 idle after done", {61'd0, busy, tx_valid, rx_ready}, 64'd0);
        end
        drain_check("R4");

        // Reject, bad closing byte, then success, with transmit backpressure
        do_reset(1'b0);
        stall_mode = 1'b1;
        session(8'h55, 5, 2, 8'h06);
        session(8'h01, 5, 2, 8'h15);
        session(8'h01, 1, 3, 8'h06);
        stall_mode = 1'b0;
        drain_check("R3");

        // Zero-length image
        do_reset(1'b0);
        session(8'h01, 0, 4, 8'h06);
        drain_check("R6");

        // Header stall, then image stall, then a full session from the base again
        do_reset(1'b0);
        begin
            int n;
            push_tx(8'h02, "R8 announce after header stall");
            send_byte(8'h01);
            #1;
            n = 1;
            while (!(tx_valid && tx_data == 8'h02) && n < LIM + 20) begin
                @(negedge clk);
                #1;
                n++;
            end
            check("R8 header gap cycles", 64'(n), 64'(LIM + 1));

            push_tx(8'h06, "R8 accept before stall");
            push_tx(8'h02, "R8 announce after image stall");
            send_byte(8'h01);
            send_byte(8'd6);
            send_byte(8'd0);
            send_byte(8'hA1);
            send_byte(8'hB2);
            #1;
            n = 1;
            while (!(tx_valid && tx_data == 8'h02) && n < LIM + 20) begin
                @(negedge clk);
                #1;
                n++;
            end
            check("R8 image gap cycles", 64'(n), 64'(LIM + 1));
            check("R8 no partial flush", {63'd0, mem_we}, 64'd0);
        end
        session(8'h01, 6, 5, 8'h06);
        drain_check("R8");

        summary();
        $finish;
    end

endmodule